// File: doc/BRIEF.md
# Character LCD 4-bit Controller

This block drives a character display controller of the common parallel type over a four-bit data bus with register-select, read/write and enable strobes. After reset it runs the four-bit initialisation handshake and a fixed configuration, then accepts commands through a valid/ready interface: write a character, move the cursor, or clear the screen. Every byte goes out as two nibble transfers, upper nibble first, each with a data setup time, a timed enable pulse, a hold cycle and a settle delay.

The display's busy flag is never read. Read/write stays low and every wait is a fixed cycle count computed as ceil(t × CLK_HZ), with a floor of one cycle, from the clock-frequency parameter. The default is 50 MHz, so 40 µs is 2000 cycles.

The sequencer is a single state machine. Its states are S_POWER, S_BOOT_SEND, S_BOOT_WAIT, S_IDLE, S_HI_SEND, S_HI_WAIT, S_LO_SEND and S_LO_WAIT, and its transitions are these:

- S_POWER moves to S_BOOT_SEND when the power-up timer expires.
- S_BOOT_SEND moves to S_BOOT_WAIT after one cycle.
- S_BOOT_WAIT moves to S_BOOT_SEND for the next boot nibble, or to S_HI_SEND after the fourth.
- S_IDLE moves to S_HI_SEND when a command is accepted.
- S_HI_SEND moves to S_HI_WAIT, and S_HI_WAIT moves to S_LO_SEND once the transfer and the inter-nibble gap are done.
- S_LO_SEND moves to S_LO_WAIT.
- S_LO_WAIT moves to S_HI_SEND for the next configuration byte, or otherwise to S_IDLE.

Top module: `lcd4_ctrl`

## Requirements
- R1: While reset is asserted and right after it, enable, data, register-select and ready are all 0. No enable pulse starts within 20 ms of reset release.
- R2: The first four transfers are single instruction nibbles 0x3, 0x3, 0x3, 0x2 with register-select 0. The enable-low gaps after them are at least 5 ms, 200 µs, 40 µs and 40 µs.
- R3: After the boot nibbles, the instruction bytes 0x28, 0x06 and 0x0C are sent in that order.
- R4: Each byte is sent as its upper nibble (bits 7:4) and then its lower nibble (bits 3:0), with at least 1 µs of enable low between the two pulses.
- R5: After the lower nibble of any byte other than clear, enable stays low for at least 40 µs before the next pulse.
- R6: cmd_kind 2'b10 or 2'b11 sends instruction 0x01 and ignores cmd_data. It is followed by at least 2 ms of enable low.
- R7: cmd_kind 2'b01 is a cursor move. If cmd_data bit 4 is 1, the instruction sent is 0x80 | cmd_data[3:0]; otherwise it is 0xC0 | cmd_data[3:0]. For example, 0x24 gives 0xC4.
- R8: cmd_kind 2'b00 sends cmd_data as a character with register-select 1 on both nibbles.
- R9: Enable stays high for exactly ceil(1 µs × CLK_HZ) cycles. Data and register-select settle at least one cycle before enable rises and stay unchanged through the cycle in which enable falls.
- R10: lcd_rw is 0 at all times.
- R11: cmd_ready is 0 until the configuration bytes have finished, and falls in the cycle after a command is accepted (cmd_valid and cmd_ready both high at a clock edge).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_kind | input | 2 | 00 character, 01 cursor, 1x clear |
| cmd_data | input | 8 | Character code or cursor position |
| lcd_d | output | 4 | Display data lines D7..D4 |
| lcd_rs | output | 1 | Register select: 0 instruction, 1 data |
| lcd_rw | output | 1 | Read/write, held at 0 |
| lcd_e | output | 1 | Enable strobe |

## Verification
A wrong boot or configuration index shows up as a wrong nibble at the very next enable rise, or as ready rising before the tenth transfer has finished. A wrong wait selection shows up as an enable-low gap shorter than the bound for that position, measured from the previous fall to the next rise. A wrong cursor or clear encoding is seen on the first nibble pulse after the command is accepted. Timing faults inside the nibble engine appear within one pulse as a wrong enable width or data moving around an edge.

// File: rtl/lcd4_pkg.sv
package lcd4_pkg;

    typedef enum logic [3:0] {
        S_POWER, S_BOOT_SEND, S_BOOT_WAIT, S_IDLE,
        S_HI_SEND, S_HI_WAIT, S_LO_SEND, S_LO_WAIT
    } seq_state_t;

    typedef enum logic [1:0] {P_IDLE, P_SETUP, P_PULSE, P_HOLD} nib_phase_t;

    localparam logic [1:0] KIND_CHAR   = 2'b00;
    localparam logic [1:0] KIND_CURSOR = 2'b01;

    // Cycles for a duration in ns, rounded up, never below one.
    function automatic longint unsigned ns_to_cyc(longint unsigned ns, longint unsigned hz);
        longint unsigned c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic logic [7:0] cfg_byte(logic [1:0] i);
        case (i)
            2'd0:    return 8'h28;
            2'd1:    return 8'h06;
            default: return 8'h0C;
        endcase
    endfunction

endpackage

// File: rtl/lcd4_timer.sv
module lcd4_timer #(
    parameter int          W       = 8,
    parameter int unsigned RST_VAL = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         busy
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= W'(RST_VAL);
        else if (load)       cnt_q <= val;
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != 0);

endmodule

// File: rtl/lcd4_nib_tx.sv
module lcd4_nib_tx
    import lcd4_pkg::*;
#(
    parameter int SU_CYC = 2,
    parameter int EN_CYC = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [3:0] nib,
    input  logic       rs_in,
    output logic [3:0] d,
    output logic       rs,
    output logic       e,
    output logic       busy,
    output logic       done
);
    localparam int CW = $clog2(((SU_CYC > EN_CYC) ? SU_CYC : EN_CYC) + 1);

    nib_phase_t    phase_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= P_IDLE;
            cnt_q   <= '0;
            d       <= '0;
            rs      <= 1'b0;
            e       <= 1'b0;
        end else begin
            unique case (phase_q)
                P_IDLE: if (start) begin
                    d       <= nib;
                    rs      <= rs_in;
                    cnt_q   <= CW'(SU_CYC - 1);
                    phase_q <= P_SETUP;
                end
                P_SETUP: if (cnt_q == 0) begin
                    e       <= 1'b1;
                    cnt_q   <= CW'(EN_CYC - 1);
                    phase_q <= P_PULSE;
                end else cnt_q <= cnt_q - 1'b1;
                P_PULSE: if (cnt_q == 0) begin
                    e       <= 1'b0;
                    phase_q <= P_HOLD;
                end else cnt_q <= cnt_q - 1'b1;
                P_HOLD: phase_q <= P_IDLE;
                default: phase_q <= P_IDLE;
            endcase
        end
    end

    assign busy = (phase_q != P_IDLE);
    assign done = (phase_q == P_HOLD);

    // R9: data and select already settled when enable rises
    a_r9_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(e) |-> $stable({d, rs}));
    // R9: data and select unchanged while enable high and in the falling cycle
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(e) |-> $stable({d, rs}));
    // R9: a new transfer is never requested mid-transfer
    a_r9_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

endmodule

// File: rtl/lcd4_ctrl.sv
module lcd4_ctrl
    import lcd4_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic [1:0] cmd_kind,
    input  logic [7:0] cmd_data,
    output logic [3:0] lcd_d,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_e
);
    localparam longint unsigned PWR_CYC    = ns_to_cyc(20_000_000, CLK_HZ);
    localparam longint unsigned LONG_CYC   = ns_to_cyc(5_000_000, CLK_HZ);
    localparam longint unsigned MID_CYC    = ns_to_cyc(200_000, CLK_HZ);
    localparam longint unsigned SETTLE_CYC = ns_to_cyc(40_000, CLK_HZ);
    localparam longint unsigned CLR_CYC    = ns_to_cyc(2_000_000, CLK_HZ);
    localparam longint unsigned GAP_CYC    = ns_to_cyc(1_000, CLK_HZ);
    localparam int              EN_CYC     = int'(ns_to_cyc(1_000, CLK_HZ));
    localparam int              SU_CYC     = int'(ns_to_cyc(40, CLK_HZ));
    localparam int              CNT_W      = $clog2(PWR_CYC + 1);

    seq_state_t       state_q, state_d;
    logic [1:0]       idx_q;
    logic [7:0]       byte_q;
    logic             rs_q, long_q, boot_q;
    logic             tx_start, tx_busy, tx_done, tx_rs;
    logic [3:0]       tx_nib;
    logic             tm_busy;
    logic [CNT_W-1:0] tm_val;
    logic             step_ok;

    assign step_ok = !tx_busy && !tm_busy;
    assign lcd_rw  = 1'b0;

    lcd4_timer #(.W(CNT_W), .RST_VAL(int'(PWR_CYC))) timer_i (
        .clk(clk), .rst_n(rst_n), .load(tx_done), .val(tm_val), .busy(tm_busy)
    );

    lcd4_nib_tx #(.SU_CYC(SU_CYC), .EN_CYC(EN_CYC)) nib_i (
        .clk(clk), .rst_n(rst_n), .start(tx_start), .nib(tx_nib), .rs_in(tx_rs),
        .d(lcd_d), .rs(lcd_rs), .e(lcd_e), .busy(tx_busy), .done(tx_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_POWER;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_POWER:     if (!tm_busy) state_d = S_BOOT_SEND;
            S_BOOT_SEND: state_d = S_BOOT_WAIT;
            S_BOOT_WAIT: if (step_ok) state_d = (idx_q == 2'd3) ? S_HI_SEND : S_BOOT_SEND;
            S_IDLE:      if (cmd_valid) state_d = S_HI_SEND;
            S_HI_SEND:   state_d = S_HI_WAIT;
            S_HI_WAIT:   if (step_ok) state_d = S_LO_SEND;
            S_LO_SEND:   state_d = S_LO_WAIT;
            S_LO_WAIT:   if (step_ok) state_d = (boot_q && idx_q != 2'd2) ? S_HI_SEND : S_IDLE;
            default:     state_d = S_POWER;
        endcase
    end

    // Outputs of the sequencer
    always_comb begin
        cmd_ready = (state_q == S_IDLE);
        tx_start  = (state_q == S_BOOT_SEND) || (state_q == S_HI_SEND) || (state_q == S_LO_SEND);
        tx_rs     = rs_q;
        unique case (state_q)
            S_BOOT_SEND: tx_nib = (idx_q == 2'd3) ? 4'h2 : 4'h3;
            S_HI_SEND:   tx_nib = byte_q[7:4];
            default:     tx_nib = byte_q[3:0];
        endcase
        unique case (state_q)
            S_BOOT_WAIT: tm_val = (idx_q == 2'd0) ? CNT_W'(LONG_CYC) :
                                  (idx_q == 2'd1) ? CNT_W'(MID_CYC) : CNT_W'(SETTLE_CYC);
            S_HI_WAIT:   tm_val = CNT_W'(GAP_CYC);
            default:     tm_val = long_q ? CNT_W'(CLR_CYC) : CNT_W'(SETTLE_CYC);
        endcase
    end

    // Sequence context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            byte_q <= '0;
            rs_q   <= 1'b0;
            long_q <= 1'b0;
            boot_q <= 1'b1;
        end else begin
            if (state_q == S_BOOT_WAIT && step_ok) begin
                if (idx_q == 2'd3) begin
                    idx_q  <= 2'd0;
                    byte_q <= cfg_byte(2'd0);
                end else idx_q <= idx_q + 1'b1;
            end
            if (state_q == S_LO_WAIT && step_ok && boot_q) begin
                if (idx_q == 2'd2) boot_q <= 1'b0;
                else begin
                    idx_q  <= idx_q + 1'b1;
                    byte_q <= cfg_byte(idx_q + 1'b1);
                end
            end
            if (state_q == S_IDLE && cmd_valid) begin
                rs_q   <= (cmd_kind == KIND_CHAR);
                long_q <= cmd_kind[1];
                if (cmd_kind[1])                byte_q <= 8'h01;
                else if (cmd_kind == KIND_CURSOR)
                    byte_q <= (cmd_data[4] ? 8'h80 : 8'hC0) | {4'h0, cmd_data[3:0]};
                else                            byte_q <= cmd_data;
            end
        end
    end

    // R11: no command taken while initialisation is running
    a_r11_locked_during_init: assert property (@(posedge clk) disable iff (!rst_n)
        boot_q |-> !cmd_ready);
    // R11: ready drops once a command is taken
    a_r11_drop_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);
    // R5: no nibble starts while a wait is still running
    a_r5_no_pulse_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> !tm_busy);
    // R1: enable stays low during the power-up wait
    a_r1_quiet_power: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_POWER) |-> !lcd_e);

endmodule

// File: tb/lcd4_ctrl_tb.sv
`timescale 1ns/1ps
module lcd4_ctrl_tb_top;
    localparam int HZ       = 2_000_000;
    localparam int C_PWR    = 40000;
    localparam int C_LONG   = 10000;
    localparam int C_MID    = 400;
    localparam int C_SETTLE = 80;
    localparam int C_GAP    = 2;
    localparam int C_CLR    = 4000;
    localparam int C_EN     = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_kind = 2'b00;
    logic [7:0] cmd_data = 8'h00;
    logic       cmd_ready, lcd_rs, lcd_rw, lcd_e;
    logic [3:0] lcd_d;

    always #10 clk = ~clk;

    lcd4_ctrl #(.CLK_HZ(HZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_kind(cmd_kind), .cmd_data(cmd_data), .lcd_d(lcd_d), .lcd_rs(lcd_rs),
        .lcd_rw(lcd_rw), .lcd_e(lcd_e)
    );

    int checks = 0, errors = 0, cyc = 0, ev_n = 0;
    logic [3:0] ev_nib [64];
    logic       ev_rs  [64];
    int         rise_c [64];
    int         fall_c [64];
    int viol_hold = 0, viol_rw = 0, viol_ready = 0, viol_width = 0;
    logic       e_p = 1'b0;
    logic [4:0] dr_p = '0;
    bit         finished = 0;

    // Bus monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (lcd_rw) viol_rw++;
            if (cmd_ready && ev_n < 10) viol_ready++;
            if (lcd_e && !e_p) begin
                if ({lcd_d, lcd_rs} != dr_p) viol_hold++;
                if (ev_n < 64) begin
                    ev_nib[ev_n] = lcd_d;
                    ev_rs[ev_n]  = lcd_rs;
                    rise_c[ev_n] = cyc;
                end
            end else if ((lcd_e || e_p) && {lcd_d, lcd_rs} != dr_p) viol_hold++;
            if (!lcd_e && e_p) begin
                if (ev_n < 64) begin
                    fall_c[ev_n] = cyc;
                    if (cyc - rise_c[ev_n] != C_EN) viol_width++;
                end
                ev_n++;
            end
            e_p  = lcd_e;
            dr_p = {lcd_d, lcd_rs};
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ev(input int n);
        int t = 0;
        while (ev_n < n && t < 60000) begin
            @(posedge clk);
            t++;
        end
        if (ev_n < n) chk(0, "transfer timeout", ev_n, n);
    endtask

    task automatic chk_byte(input int i, input logic [7:0] b, input logic r, input string req);
        chk(ev_nib[i] == b[7:4], req, ev_nib[i], b[7:4]);
        chk(ev_nib[i+1] == b[3:0], req, ev_nib[i+1], b[3:0]);
        chk(ev_rs[i] == r && ev_rs[i+1] == r, req, ev_rs[i], r);
        chk(rise_c[i+1] - fall_c[i] >= C_GAP, "R4 nibble gap", rise_c[i+1] - fall_c[i], C_GAP);
    endtask

    task automatic send(input logic [1:0] k, input logic [7:0] v);
        int t = 0;
        @(negedge clk);
        while (!cmd_ready && t < 20000) begin
            @(negedge clk);
            t++;
        end
        cmd_valid = 1'b1;
        cmd_kind  = k;
        cmd_data  = v;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_ready == 1'b0, "R11 ready after accept", cmd_ready, 0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(lcd_e == 0 && lcd_d == 0 && lcd_rs == 0, "R1 reset outputs", {lcd_e, lcd_d, lcd_rs}, 0);
        chk(cmd_ready == 0, "R1 reset ready", cmd_ready, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_boot;
        wait_ev(4);
        chk(rise_c[0] >= C_PWR, "R1 power wait", rise_c[0], C_PWR);
        chk(ev_nib[0] == 4'h3 && ev_nib[1] == 4'h3 && ev_nib[2] == 4'h3, "R2 boot 0x3", ev_nib[2], 3);
        chk(ev_nib[3] == 4'h2, "R2 boot 0x2", ev_nib[3], 2);
        chk(!ev_rs[0] && !ev_rs[1] && !ev_rs[2] && !ev_rs[3], "R2 boot rs", ev_rs[3], 0);
        chk(rise_c[1] - fall_c[0] >= C_LONG, "R2 gap 5ms", rise_c[1] - fall_c[0], C_LONG);
        chk(rise_c[2] - fall_c[1] >= C_MID, "R2 gap 200us", rise_c[2] - fall_c[1], C_MID);
        chk(rise_c[3] - fall_c[2] >= C_SETTLE, "R2 gap 40us", rise_c[3] - fall_c[2], C_SETTLE);
        wait_ev(10);
        chk(rise_c[4] - fall_c[3] >= C_SETTLE, "R2 gap after 0x2", rise_c[4] - fall_c[3], C_SETTLE);
        chk_byte(4, 8'h28, 1'b0, "R3 function set");
        chk_byte(6, 8'h06, 1'b0, "R3 entry mode");
        chk_byte(8, 8'h0C, 1'b0, "R3 display on");
        chk(rise_c[6] - fall_c[5] >= C_SETTLE, "R5 settle", rise_c[6] - fall_c[5], C_SETTLE);
    endtask

    task automatic t_char;
        send(2'b00, 8'h68);
        wait_ev(12);
        chk_byte(10, 8'h68, 1'b1, "R8 character");
    endtask

    task automatic t_cursor;
        send(2'b01, 8'h24);
        send(2'b01, 8'h13);
        wait_ev(16);
        chk_byte(12, 8'hC4, 1'b0, "R7 cursor line 2");
        chk_byte(14, 8'h83, 1'b0, "R7 cursor line 1");
        chk(rise_c[12] - fall_c[11] >= C_SETTLE, "R5 settle after char", rise_c[12] - fall_c[11], C_SETTLE);
    endtask

    task automatic t_clear;
        send(2'b10, 8'hFF);
        send(2'b00, 8'h41);
        wait_ev(20);
        chk_byte(16, 8'h01, 1'b0, "R6 clear code");
        chk(rise_c[18] - fall_c[17] >= C_CLR, "R6 clear wait", rise_c[18] - fall_c[17], C_CLR);
        chk_byte(18, 8'h41, 1'b1, "R8 character after clear");
    endtask

    task automatic t_protocol;
        repeat (20) @(posedge clk);
        chk(viol_hold == 0, "R9 data stability", viol_hold, 0);
        chk(viol_width == 0, "R9 enable width", viol_width, 0);
        chk(viol_rw == 0, "R10 rw low", viol_rw, 0);
        chk(viol_ready == 0, "R11 ready during init", viol_ready, 0);
        chk(ev_n == 20, "R11 no extra transfers", ev_n, 20);
    endtask

    initial begin
        t_reset();
        t_boot();
        t_char();
        t_cursor();
        t_clear();
        t_protocol();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            chk(0, "watchdog", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule